// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is the device side of a three-wire serial EEPROM, written as synthesizable logic clocked by a fast system clock. It samples a chip-select line, a serial clock and a serial data input. It decodes each instruction, which is a start bit, a two-bit opcode and an address field. It then runs that instruction against an internal byte array. The supported instructions are read one location, erase one location, write one location, unlock, lock, clear every location and fill every location with one value. A strap input chooses between byte organisation and 16-bit word organisation.

Read data and a ready/busy status leave on a serial data output. That output is qualified by an output-enable, which stands in for a tri-state driver. Programming time is modelled by a counter loaded with a parameter. A host drives the serial lines and polls the status after each modifying command.

Top module: `eep_target`

## Requirements
- R1: After reset the output-enable is low and the write-unlock latch is cleared, so a write issued before any unlock leaves the addressed location unchanged.
- R2: While chip select is high, zero bits on the data input before the first 1 are ignored. The first 1 sampled on a serial clock rise is the start bit.
- R3: Opcode 10 is a read. On the serial clock rise that samples the last address bit, the output shows a 0 dummy bit. Each following rise shows the next data bit, most significant bit first.
- R4: With the strap low, the address field is 9 bits and data is 8 bits. With the strap high, the address field is 8 bits and data is 16 bits. The top address bit is ignored in both cases. Word w occupies byte 2w as its high half and byte 2w+1 as its low half.
- R5: Opcode 00 with the top two address bits 11 sets the unlock latch, and with 00 clears it. Erase, write, clear-all and fill-all are ignored while the latch is cleared.
- R6: Opcode 11 (erase) sets the addressed location to all ones. Opcode 01 (write) stores the data that follows the address.
- R7: Opcode 00 with top address bits 10 sets every location to all ones. With 01 it writes the data that follows to every location.
- R8: Once a modifying command has started programming and chip select has gone low, the next raise of chip select enables the output and shows 0 while programming runs and 1 once it is done. Programming lasts PROG_CYCLES system clocks. A command that was ignored starts no status.
- R9: The output-enable is low whenever chip select is low, and high only while read data or status is being shown.
- R10: Lowering chip select mid-instruction abandons that instruction without changing storage. The next instruction is decoded from a fresh start bit.
- R11: While programming is in progress, start bits are not accepted and the status output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock; inputs are sampled on its rising edge |
| sdi | input | 1 | Serial data input |
| org_word | input | 1 | Organisation strap: 0 byte, 1 16-bit word |
| sdo | output | 1 | Serial data output (read data or ready status) |
| sdo_en | output | 1 | Output-enable for sdo; low means high impedance |

## Verification
The bench keeps the default 9-bit address field, so the whole 256-byte array can be swept. It sets PROG_CYCLES to 30, which keeps each status poll short enough that every byte can be written and read back. It also exercises every word location in word organisation, so the mapping between word and byte layouts can be checked in both directions. The short programming time also lets the bench clock a full instruction into the busy window and then watch the ready transition.

// File: rtl/eep_pkg.sv
// Shared encodings for the three-wire EEPROM target.
// Assumes: opcode and sub-command values are fixed by the serial protocol.
package eep_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_OPC, S_ADR, S_DAT, S_RD, S_DONE, S_STAT
    } eep_state_t;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } eep_op_t;

    typedef enum logic [1:0] {
        X_LOCK   = 2'b00,
        X_FILL   = 2'b01,
        X_CLEAR  = 2'b10,
        X_UNLOCK = 2'b11
    } eep_ext_t;
endpackage

// File: rtl/eep_edge.sv
// Edge detector for the serial clock and chip select.
// Assumes: inputs are already synchronous to clk and each level lasts >= 2 clk.
module eep_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic sel,
    output logic sck_rise,
    output logic sel_rise
);
    logic sck_q;
    logic sel_q;

    // Remember the previous level of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            sck_q <= sck;
            sel_q <= sel;
        end
    end

    assign sck_rise = sck & ~sck_q;
    assign sel_rise = sel & ~sel_q;
endmodule

// File: rtl/eep_prog_timer.sv
// Programming-time model: a down counter that is busy for PROG_CYCLES clocks.
// Assumes: start is only pulsed while idle.
module eep_prog_timer #(
    parameter int PROG_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(PROG_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);

    p_busy_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt == $past(cnt) - CW'(1)));
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/eep_array.sv
// Byte-wide storage with single-location and whole-array write ports.
// Assumes: word accesses use an even byte index; contents are not reset.
module eep_array #(
    parameter int BW    = 8,
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              word_mode,
    input  logic              wr_en,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [2*BW-1:0]   wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [2*BW-1:0]   rd_data
);
    localparam int DW    = 2 * BW;
    localparam int DEPTH = 1 << IDX_W;

    logic [BW-1:0] mem [DEPTH];
    logic [IDX_W-1:0] wr_odd;
    logic [IDX_W-1:0] rd_odd;

    assign wr_odd = {wr_idx[IDX_W-1:1], 1'b1};
    assign rd_odd = {rd_idx[IDX_W-1:1], 1'b1};

    // Apply single-location or whole-array writes.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (word_mode && (i % 2 == 0))
                    mem[IDX_W'(i)] <= wr_data[DW-1:BW];
                else
                    mem[IDX_W'(i)] <= wr_data[BW-1:0];
            end
        end else if (wr_en) begin
            if (word_mode) begin
                mem[wr_idx] <= wr_data[DW-1:BW];
                mem[wr_odd] <= wr_data[BW-1:0];
            end else begin
                mem[wr_idx] <= wr_data[BW-1:0];
            end
        end
    end

    // Combinational read of one byte or one byte pair.
    always_comb begin
        if (word_mode)
            rd_data = {mem[rd_idx], mem[rd_odd]};
        else
            rd_data = {{BW{1'b0}}, mem[rd_idx]};
    end
endmodule

// File: rtl/eep_cmd.sv
// Serial instruction decoder and sequencer.
// Shifts the opcode, address and data in, drives the read shifter and
// status, and issues storage writes and programming starts.
// Assumes: sck_rise and sel_rise never coincide; AW >= 3.
module eep_cmd #(
    parameter int AW = 9,
    parameter int BW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           sdi,
    input  logic           org_word,
    input  logic           sck_rise,
    input  logic           sel_rise,
    input  logic           busy,
    input  logic [2*BW-1:0] rd_data,
    output logic [AW-2:0]  rd_idx,
    output logic [AW-2:0]  wr_idx,
    output logic [2*BW-1:0] wr_data,
    output logic           wr_en,
    output logic           fill_en,
    output logic           prog_start,
    output logic           sdo,
    output logic           sdo_en
);
    import eep_pkg::*;

    localparam int DW    = 2 * BW;
    localparam int IDX_W = AW - 1;
    localparam int MAXL  = (AW > DW) ? AW : DW;
    localparam int CW    = $clog2(MAXL + 1);

    eep_state_t     st;
    eep_op_t        op;
    logic [CW-1:0]  cnt;
    logic [AW-1:0]  adr_sh;
    logic [DW-1:0]  dat_sh;
    logic [DW:0]    rd_sh;
    logic           wel;
    logic           pend;
    logic [AW-1:0]  adr_nx;
    logic [DW-1:0]  dat_nx;
    logic [CW-1:0]  alen_m1;
    logic [CW-1:0]  dlen_m1;

    // Byte index of an address field for the current organisation.
    function automatic logic [IDX_W-1:0] to_idx(input logic [AW-1:0] a, input logic w);
        return w ? {a[AW-3:0], 1'b0} : a[AW-2:0];
    endfunction

    // Sub-command carried in the top two bits of the address field.
    function automatic eep_ext_t top2(input logic [AW-1:0] a, input logic w);
        return eep_ext_t'(w ? a[AW-2:AW-3] : a[AW-1:AW-2]);
    endfunction

    assign adr_nx  = {adr_sh[AW-2:0], sdi};
    assign dat_nx  = {dat_sh[DW-2:0], sdi};
    assign alen_m1 = org_word ? CW'(AW - 2) : CW'(AW - 1);
    assign dlen_m1 = org_word ? CW'(DW - 1) : CW'(BW - 1);
    assign rd_idx  = to_idx(adr_nx, org_word);

    // Instruction sequencer: one step per serial clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            op         <= OP_EXT;
            cnt        <= '0;
            adr_sh     <= '0;
            dat_sh     <= '0;
            rd_sh      <= '0;
            wel        <= 1'b0;
            pend       <= 1'b0;
            wr_en      <= 1'b0;
            fill_en    <= 1'b0;
            prog_start <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
        end else begin
            wr_en      <= 1'b0;
            fill_en    <= 1'b0;
            prog_start <= 1'b0;
            if (!sel) begin
                st    <= S_IDLE;
                rd_sh <= '0;
            end else if (sel_rise) begin
                st <= pend ? S_STAT : S_IDLE;
            end else if (sck_rise) begin
                case (st)
                    S_IDLE, S_STAT: begin
                        if (sdi && !busy) begin
                            st   <= S_OPC;
                            cnt  <= '0;
                            pend <= 1'b0;
                        end
                    end
                    S_OPC: begin
                        op <= eep_op_t'({op[0], sdi});
                        if (cnt == CW'(1)) begin
                            cnt <= '0;
                            st  <= S_ADR;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    S_ADR: begin
                        adr_sh <= adr_nx;
                        cnt    <= cnt + CW'(1);
                        if (cnt == alen_m1) begin
                            cnt <= '0;
                            case (op)
                                OP_READ: begin
                                    st <= S_RD;
                                    if (org_word)
                                        rd_sh <= {1'b0, rd_data};
                                    else
                                        rd_sh <= {1'b0, rd_data[BW-1:0], {BW{1'b0}}};
                                end
                                OP_ERASE: begin
                                    st <= S_DONE;
                                    if (wel) begin
                                        wr_idx     <= to_idx(adr_nx, org_word);
                                        wr_data    <= '1;
                                        wr_en      <= 1'b1;
                                        prog_start <= 1'b1;
                                        pend       <= 1'b1;
                                    end
                                end
                                OP_WRITE: begin
                                    st     <= S_DAT;
                                    wr_idx <= to_idx(adr_nx, org_word);
                                end
                                default: begin
                                    case (top2(adr_nx, org_word))
                                        X_UNLOCK: begin
                                            wel <= 1'b1;
                                            st  <= S_DONE;
                                        end
                                        X_LOCK: begin
                                            wel <= 1'b0;
                                            st  <= S_DONE;
                                        end
                                        X_CLEAR: begin
                                            st <= S_DONE;
                                            if (wel) begin
                                                wr_data    <= '1;
                                                fill_en    <= 1'b1;
                                                prog_start <= 1'b1;
                                                pend       <= 1'b1;
                                            end
                                        end
                                        default: st <= S_DAT;
                                    endcase
                                end
                            endcase
                        end
                    end
                    S_DAT: begin
                        dat_sh <= dat_nx;
                        cnt    <= cnt + CW'(1);
                        if (cnt == dlen_m1) begin
                            cnt <= '0;
                            st  <= S_DONE;
                            if (wel) begin
                                wr_data    <= org_word ? dat_nx : {{BW{1'b0}}, dat_nx[BW-1:0]};
                                wr_en      <= (op == OP_WRITE);
                                fill_en    <= (op != OP_WRITE);
                                prog_start <= 1'b1;
                                pend       <= 1'b1;
                            end
                        end
                    end
                    S_RD: rd_sh <= {rd_sh[DW-1:0], 1'b0};
                    default: ;
                endcase
            end
        end
    end

    assign sdo    = (st == S_STAT) ? !busy : rd_sh[DW];
    assign sdo_en = sel && ((st == S_RD) || (st == S_STAT));

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (st == S_IDLE));
    p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (st == S_STAT)) |=> (st != S_OPC));
    p_gated_by_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || fill_en) |-> wel);
    p_rd_dummy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == S_RD) |-> !rd_sh[DW]);
endmodule

// File: rtl/eep_target.sv
// Top level of the three-wire serial EEPROM target.
// Assumes: serial lines are synchronous to clk and much slower than it.
module eep_target #(
    parameter int AW          = 9,
    parameter int BW          = 8,
    parameter int PROG_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck,
    input  logic sdi,
    input  logic org_word,
    output logic sdo,
    output logic sdo_en
);
    localparam int DW    = 2 * BW;
    localparam int IDX_W = AW - 1;

    logic             sck_rise;
    logic             sel_rise;
    logic             busy;
    logic             wr_en;
    logic             fill_en;
    logic             prog_start;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [DW-1:0]    wr_data;
    logic [DW-1:0]    rd_data;

    eep_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sel      (sel),
        .sck_rise (sck_rise),
        .sel_rise (sel_rise)
    );

    eep_cmd #(.AW(AW), .BW(BW)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .sdi        (sdi),
        .org_word   (org_word),
        .sck_rise   (sck_rise),
        .sel_rise   (sel_rise),
        .busy       (busy),
        .rd_data    (rd_data),
        .rd_idx     (rd_idx),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .wr_en      (wr_en),
        .fill_en    (fill_en),
        .prog_start (prog_start),
        .sdo        (sdo),
        .sdo_en     (sdo_en)
    );

    eep_array #(.BW(BW), .IDX_W(IDX_W)) u_array (
        .clk       (clk),
        .word_mode (org_word),
        .wr_en     (wr_en),
        .fill_en   (fill_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy)
    );
endmodule

// File: tb/eep_target_test.sv
// Self-checking bench: sweeps every byte and word location against a model.
module eep_target_test;
    localparam int CLK_P = 10;
    localparam int PROG  = 30;

    logic clk = 1'b0;
    logic rst_n, sel, sck, sdi, org;
    logic sdo, sdo_en;
    int   checks = 0;
    int   errors = 0;
    logic [7:0] model [256];

    always #(CLK_P / 2) clk = ~clk;

    eep_target #(.AW(9), .BW(8), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sck(sck), .sdi(sdi),
        .org_word(org), .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit_rd(input bit b, output bit o);
        sdi = b;
        sck = 1'b1;
        nclk(2);
        o = sdo;
        sck = 1'b0;
        nclk(1);
    endtask

    task automatic sbit(input bit b);
        bit o;
        sbit_rd(b, o);
    endtask

    task automatic send(input int v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(bit'((v >> i) & 1));
    endtask

    task automatic cs_up;
        sel = 1'b1;
        nclk(2);
    endtask

    task automatic cs_down;
        sel = 1'b0;
        sdi = 1'b0;
        nclk(2);
    endtask

    function automatic int alen();
        return org ? 8 : 9;
    endfunction

    function automatic int dlen();
        return org ? 16 : 8;
    endfunction

    // Status poll: busy first, then ready within the programming time.
    task automatic wait_ready(input string req);
        int n;
        bit first;
        cs_up;
        first = sdo;
        chk(sdo_en == 1'b1, req, sdo_en, 1);
        chk(first == 1'b0, req, first, 0);
        n = 0;
        while (sdo !== 1'b1 && n < 200) begin
            nclk(1);
            n++;
        end
        chk(n > 0 && n <= PROG, req, n, PROG);
        cs_down;
    endtask

    task automatic ext(input int code, input bit prog, input int data);
        cs_up;
        sbit(1'b1);
        send(0, 2);
        send(code, 2);
        send(0, alen() - 2);
        if (code == 1) send(data, dlen());
        cs_down;
        if (prog) wait_ready("R8");
    endtask

    task automatic do_write(input int addr, input int data, input bit prog);
        cs_up;
        sbit(1'b1);
        send(1, 2);
        send(addr, alen());
        send(data, dlen());
        cs_down;
        if (prog) wait_ready("R8");
    endtask

    task automatic do_erase(input int addr);
        cs_up;
        sbit(1'b1);
        send(3, 2);
        send(addr, alen());
        cs_down;
        wait_ready("R8");
    endtask

    task automatic do_read(input int addr, output int val, output bit dummy);
        bit o;
        cs_up;
        sbit(1'b1);
        send(2, 2);
        for (int i = alen() - 1; i >= 0; i--) sbit_rd(bit'((addr >> i) & 1), o);
        dummy = o;
        val = 0;
        for (int i = 0; i < dlen(); i++) begin
            sbit_rd(1'b0, o);
            val = (val << 1) | int'(o);
        end
        cs_down;
    endtask

    function automatic int word_of(input int w);
        return (int'(model[2 * w]) << 8) | int'(model[2 * w + 1]);
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int v;
        bit d;
        rst_n = 1'b0; sel = 1'b0; sck = 1'b0; sdi = 1'b0; org = 1'b0;
        nclk(4);
        chk(sdo_en == 1'b0, "R1", sdo_en, 0);
        rst_n = 1'b1;
        nclk(2);

        // R5: unlock then clear everything; status follows.
        ext(3, 1'b0, 0);
        ext(2, 1'b1, 0);
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;

        // R1: reset clears the latch, so this write is ignored.
        rst_n = 1'b0; nclk(3); rst_n = 1'b1; nclk(2);
        do_write(5, 8'h3C, 1'b0);
        cs_up;
        chk(sdo_en == 1'b0, "R8", sdo_en, 0);
        cs_down;
        do_read(5, v, d);
        chk(v == 8'hFF, "R1", v, 8'hFF);

        // R9: output-enable low with chip select low.
        chk(sdo_en == 1'b0, "R9", sdo_en, 0);

        // R4/R6 byte sweep, top address bit flipped between write and read.
        ext(3, 1'b0, 0);
        for (int a = 0; a < 256; a++) begin
            model[a] = 8'((a * 37 + 11) & 8'hFF);
            do_write(a | ((a & 1) << 8), int'(model[a]), 1'b1);
        end
        for (int a = 0; a < 256; a++) begin
            do_read(a | ((~a & 1) << 8), v, d);
            chk(v == int'(model[a]), "R4", v, model[a]);
            if (a < 4) chk(d == 1'b0, "R3", d, 0);
        end

        // R6: erase one location.
        do_erase(7);
        model[7] = 8'hFF;
        do_read(7, v, d);
        chk(v == 8'hFF, "R6", v, 8'hFF);

        // R2: leading zeros before the start bit.
        cs_up;
        send(0, 3);
        sbit(1'b1);
        send(2, 2);
        send(9, 9);
        v = 0;
        for (int i = 0; i < 8; i++) begin
            bit o;
            sbit_rd(1'b0, o);
            v = (v << 1) | int'(o);
        end
        chk(sdo_en == 1'b1, "R9", sdo_en, 1);
        cs_down;
        chk(v == int'(model[9]), "R2", v, model[9]);

        // R10: abort in data phase and in address phase.
        cs_up; sbit(1'b1); send(1, 2); send(10, 9); send(0, 4); cs_down;
        cs_up; sbit(1'b1); send(3, 2); send(11, 5); cs_down;
        do_read(10, v, d);
        chk(v == int'(model[10]), "R10", v, model[10]);
        do_read(11, v, d);
        chk(v == int'(model[11]), "R10", v, model[11]);

        // R11: start bits ignored while programming.
        do_write(20, 8'h5A, 1'b0);
        model[20] = 8'h5A;
        cs_up;
        chk(sdo == 1'b0, "R11", sdo, 0);
        sbit(1'b1); send(2, 2); send(3, 4);
        chk(sdo == 1'b0 && sdo_en == 1'b1, "R11", sdo, 0);
        nclk(PROG);
        chk(sdo == 1'b1, "R11", sdo, 1);
        cs_down;
        do_read(20, v, d);
        chk(v == 8'h5A, "R6", v, 8'h5A);

        // Word organisation: fill all, then write each word.
        org = 1'b1;
        ext(1, 1'b1, 16'hA55A);
        for (int i = 0; i < 256; i++) model[i] = (i % 2 == 0) ? 8'hA5 : 8'h5A;
        for (int w = 0; w < 128; w++) begin
            do_read(w | ((w & 1) << 7), v, d);
            chk(v == 16'hA55A, "R7", v, 16'hA55A);
        end
        for (int w = 0; w < 128; w++) begin
            v = (w * 16'h0123) ^ 16'hBEEF;
            model[2 * w]     = 8'(v >> 8);
            model[2 * w + 1] = 8'(v);
            do_write(w | ((~w & 1) << 7), v & 16'hFFFF, 1'b1);
        end
        for (int w = 0; w < 128; w++) begin
            do_read(w, v, d);
            chk(v == word_of(w), "R4", v, word_of(w));
        end

        // R4: word-to-byte mapping seen from byte organisation.
        org = 1'b0;
        for (int a = 0; a < 32; a++) begin
            do_read(a, v, d);
            chk(v == int'(model[a]), "R4", v, model[a]);
        end

        // R7 clear-all, then R5 lock blocks a write.
        org = 1'b1;
        ext(2, 1'b1, 0);
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        ext(0, 1'b0, 0);
        do_write(3, 16'h1234, 1'b0);
        for (int w = 0; w < 8; w++) begin
            do_read(w, v, d);
            chk(v == 16'hFFFF, "R7", v, 16'hFFFF);
        end
        do_read(3, v, d);
        chk(v == 16'hFFFF, "R5", v, 16'hFFFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule